// File: doc/BRIEF.md
# Posted Write Burst Disconnect Controller

This block is the target-side write path of a bus bridge. An initiator opens a memory write burst with a one-cycle address strobe; the controller claims the burst, posts every accepted data phase with its byte enables into a small buffer, and raises a stop request on the data phase that will be the last one it takes. When the burst ends it replays the posted dwords on the far bus as one or more address-plus-data transactions. If the far target disconnects, the controller restarts at the exact next dword address.

The stop decision is made again on every data phase from the address of that phase. It does not depend on what happened on the bus before the burst began. Five things can end a burst:
- reaching the last dword before a 1 KB boundary;
- reaching the last dword of a cache line, for invalidate-type writes only;
- a programmable burst length limit;
- a posting-disable control, from configuration or from a pin;
- a full buffer.

When the burst limit is shorter than the cache line, an invalidate-type write is forwarded as a plain memory write.

The controller's states are:
- IDLE: waits for an address strobe that carries a posting command.
- ACCEPT: takes data phases.
- RADDR: drives a one-cycle replay address phase.
- RDATA: presents buffered dwords to the far target.

The transitions are:
- IDLE to ACCEPT on a posting command.
- ACCEPT to RADDR on the final accepted phase.
- RADDR to RDATA always.
- RDATA to IDLE when the last dword is taken.
- RDATA to RADDR on a far disconnect with data still left.

Top module: `pwb_disconnect_ctl`

## Requirements
- R1: Only command 4'b0111 (memory write) and 4'b1111 (memory write and invalidate) are claimed. With any other command, `wr_ready` stays low and no replay takes place.
- R2: A data phase whose dword address has bits [9:2] all ones (low ten address bits 0x3FC) is the last phase accepted. A burst starting at 0x...3F8 therefore takes two phases.
- R3: For command 4'b1111 with `cls` from 1 to 15, the phase whose dword index (address/4) plus one is a multiple of `cls` is the last phase accepted.
- R4: The cache line stop never applies to command 4'b0111. It also does not apply when `cls` is 0 or above 15.
- R5: With `burst_lim` nonzero, the burst ends on phase number `burst_lim`. A value of 0 means no limit.
- R6: A 4'b1111 burst with `burst_lim` nonzero, `cls` from 1 to 15 and `burst_lim` < `cls` is replayed with `rp_cmd` 4'b0111. Otherwise the command is replayed unchanged.
- R7: While `post_dis_cfg` or `post_dis_pin` is high, every burst ends after its first data phase.
- R8: The post buffer holds 4 dwords, so the fourth accepted phase is always the last.
- R9: `stop_req` is high only during an accepted data phase, and `wr_ready` is low in the cycle after it.
- R10: The replay drives one `rp_start` cycle with the burst address. It then presents the dwords in order with their byte enables, and `rp_last` is high on the final one.
- R11: After `far_disc`, a new `rp_start` follows at base + 4 × (dwords taken so far), using a full-width address add. A disconnect with `far_ready` low retries the same dword.
- R12: After reset, `wr_ready`, `stop_req`, `rp_start`, `rp_valid` and `rp_last` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Address phase strobe from the initiator |
| cmd | input | 4 | Bus command of the burst |
| addr | input | 32 | Byte address of the burst |
| wr_valid | input | 1 | Initiator has a data phase ready |
| wr_data | input | 32 | Write data of the phase |
| wr_be | input | 4 | Byte enables of the phase |
| wr_last | input | 1 | Initiator marks this phase as its final one |
| cls | input | 8 | Cache line size in dwords |
| burst_lim | input | 8 | Maximum data phases per burst, 0 = none |
| post_dis_cfg | input | 1 | Posting disable, configuration bit |
| post_dis_pin | input | 1 | Posting disable, external pin |
| far_ready | input | 1 | Far target takes the presented dword |
| far_disc | input | 1 | Far target ends the current replay transaction |
| wr_ready | output | 1 | Controller is accepting data phases |
| stop_req | output | 1 | Stop request: this phase is the last accepted |
| rp_start | output | 1 | Replay address phase |
| rp_addr | output | 32 | Address of the dword being replayed |
| rp_cmd | output | 4 | Command used for the replay |
| rp_valid | output | 1 | Replay dword is presented |
| rp_data | output | 32 | Replay data |
| rp_be | output | 4 | Replay byte enables |
| rp_last | output | 1 | Presented dword is the final one of the burst |

## Verification
The directed scenarios start bursts at 0x3F8 and 0x3FC. A design that checked the boundary only at the address phase would take a second dword across the 1 KB line. The cache line cases use a size of 3, which is not a power of two, as well as a size of 8, a plain write and an out-of-range size. A modulo built from low address bits alone would stop at the wrong phase. The burst-limit case with the limit below the line size expects the invalidate command to be demoted; the unchanged command is expected when no limit is set. The replay cases disconnect on the dword at 0x3F8 and also without data. A design that cleared the low ten address bits on resume would restart at 0x...000 instead of 0x...3FC, and one that advanced on a data-less disconnect would drop a dword.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

    localparam logic [3:0] CMD_MWR = 4'b0111;
    localparam logic [3:0] CMD_MWI = 4'b1111;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACCEPT,
        ST_RADDR,
        ST_RDATA
    } pwb_state_e;

    function automatic logic is_post_cmd(input logic [3:0] c);
        return (c == CMD_MWR) || (c == CMD_MWI);
    endfunction

endpackage

// File: rtl/pwb_stop_calc.sv
module pwb_stop_calc #(
    parameter int LW = 8
) (
    input  logic [7:0]    idx_lo,
    input  logic [LW-1:0] phase_cnt,
    input  logic [LW-1:0] lim,
    input  logic [LW-1:0] line_left,
    input  logic          line_on,
    input  logic          post_dis,
    input  logic          buf_last,
    output logic          last_phase
);
    logic at_kb, at_line, at_lim;

    always_comb begin
        at_kb      = &idx_lo;
        at_line    = line_on && (line_left == LW'(1));
        at_lim     = (lim != '0) && ((phase_cnt + LW'(1)) >= lim);
        last_phase = at_kb || at_line || at_lim || post_dis || buf_last;
    end
endmodule

// File: rtl/pwb_post_buf.sv
module pwb_post_buf #(
    parameter int DEPTH = 4,
    parameter int DW    = 32,
    localparam int BEW  = DW / 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           wr_en,
    input  logic [DW-1:0]  wr_data,
    input  logic [BEW-1:0] wr_be,
    input  logic [CW-1:0]  rd_idx,
    output logic [DW-1:0]  rd_data,
    output logic [BEW-1:0] rd_be,
    output logic [CW-1:0]  count
);
    logic [CW-1:0]  wr_ptr;
    logic [DW-1:0]  slot_d [DEPTH];
    logic [BEW-1:0] slot_b [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     wr_ptr <= '0;
        else if (clr)   wr_ptr <= '0;
        else if (wr_en) wr_ptr <= wr_ptr + CW'(1);
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_d[g] <= '0;
                slot_b[g] <= '0;
            end else if (wr_en && !clr && wr_ptr == CW'(g)) begin
                slot_d[g] <= wr_data;
                slot_b[g] <= wr_be;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        rd_be   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_idx == CW'(i)) begin
                rd_data = slot_d[i];
                rd_be   = slot_b[i];
            end
        end
    end

    assign count = wr_ptr;
endmodule

// File: rtl/pwb_disconnect_ctl.sv
module pwb_disconnect_ctl
    import pwb_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int DEPTH = 4,
    parameter int LW    = 8,
    parameter int MAXCL = 15,
    localparam int BEW  = DW / 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [3:0]     cmd,
    input  logic [AW-1:0]  addr,
    input  logic           wr_valid,
    input  logic [DW-1:0]  wr_data,
    input  logic [BEW-1:0] wr_be,
    input  logic           wr_last,
    input  logic [LW-1:0]  cls,
    input  logic [LW-1:0]  burst_lim,
    input  logic           post_dis_cfg,
    input  logic           post_dis_pin,
    input  logic           far_ready,
    input  logic           far_disc,
    output logic           wr_ready,
    output logic           stop_req,
    output logic           rp_start,
    output logic [AW-1:0]  rp_addr,
    output logic [3:0]     rp_cmd,
    output logic           rp_valid,
    output logic [DW-1:0]  rp_data,
    output logic [BEW-1:0] rp_be,
    output logic           rp_last
);
    pwb_state_e     state, nxt;
    logic [AW-1:0]  base_addr;
    logic [3:0]     cmd_eff;
    logic [LW-1:0]  phase_cnt, line_left, line_init;
    logic           line_on;
    logic [CW-1:0]  rd_idx, buf_cnt;
    logic [DW-1:0]  buf_data;
    logic [BEW-1:0] buf_be;
    logic [AW-1:0]  idx_ext, cls_div, rem;
    logic [7:0]     idx_lo;
    logic           claim, take, last_phase, cls_ok, demote, final_dw;

    // Address-phase decode
    always_comb begin
        claim     = (state == ST_IDLE) && start && is_post_cmd(cmd);
        cls_ok    = (cls != '0) && (cls <= LW'(MAXCL));
        demote    = (cmd == CMD_MWI) && (burst_lim != '0) && cls_ok && (burst_lim < cls);
        idx_ext   = addr >> 2;
        cls_div   = cls_ok ? AW'(cls) : AW'(1);
        rem       = idx_ext % cls_div;
        line_init = cls - LW'(rem);
    end

    // Per-phase stop decision
    assign take   = (state == ST_ACCEPT) && wr_valid;
    assign idx_lo = base_addr[9:2] + phase_cnt[7:0];

    pwb_stop_calc #(.LW(LW)) u_stop (
        .idx_lo     (idx_lo),
        .phase_cnt  (phase_cnt),
        .lim        (burst_lim),
        .line_left  (line_left),
        .line_on    (line_on),
        .post_dis   (post_dis_cfg || post_dis_pin),
        .buf_last   (phase_cnt == LW'(DEPTH - 1)),
        .last_phase (last_phase)
    );

    pwb_post_buf #(.DEPTH(DEPTH), .DW(DW)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (claim),
        .wr_en   (take),
        .wr_data (wr_data),
        .wr_be   (wr_be),
        .rd_idx  (rd_idx),
        .rd_data (buf_data),
        .rd_be   (buf_be),
        .count   (buf_cnt)
    );

    assign final_dw = (rd_idx == buf_cnt - CW'(1));

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (claim) nxt = ST_ACCEPT;
            ST_ACCEPT: if (take && (last_phase || wr_last)) nxt = ST_RADDR;
            ST_RADDR:  nxt = ST_RDATA;
            ST_RDATA:  if (far_ready && final_dw) nxt = ST_IDLE;
                       else if (far_disc)         nxt = ST_RADDR;
            default:   nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Burst context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_addr <= '0;
            cmd_eff   <= CMD_MWR;
            phase_cnt <= '0;
            line_left <= '0;
            line_on   <= 1'b0;
            rd_idx    <= '0;
        end else begin
            if (claim) begin
                base_addr <= addr & ~AW'(3);
                cmd_eff   <= demote ? CMD_MWR : cmd;
                phase_cnt <= '0;
                line_left <= line_init;
                line_on   <= (cmd == CMD_MWI) && cls_ok && !demote;
                rd_idx    <= '0;
            end
            if (take) begin
                phase_cnt <= phase_cnt + LW'(1);
                line_left <= line_left - LW'(1);
            end
            if (state == ST_RDATA && far_ready) rd_idx <= rd_idx + CW'(1);
        end
    end

    // Outputs
    always_comb begin
        wr_ready = (state == ST_ACCEPT);
        stop_req = take && last_phase;
        rp_start = (state == ST_RADDR);
        rp_valid = (state == ST_RDATA);
        rp_last  = rp_valid && final_dw;
        rp_cmd   = cmd_eff;
        rp_addr  = (rp_start || rp_valid) ? base_addr + (AW'(rd_idx) << 2) : '0;
        rp_data  = rp_valid ? buf_data : '0;
        rp_be    = rp_valid ? buf_be : '0;
    end
endmodule

// File: rtl/pwb_disconnect_chk.sv
module pwb_disconnect_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic [3:0] cmd,
    input logic       wr_valid,
    input logic       post_dis_cfg,
    input logic       post_dis_pin,
    input logic       far_ready,
    input logic       far_disc,
    input logic       wr_ready,
    input logic       stop_req,
    input logic       rp_start,
    input logic [3:0] rp_cmd,
    input logic       rp_valid,
    input logic       rp_last
);
    // R1
    nonpost_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(start && (cmd == 4'b0111 || cmd == 4'b1111)) && !wr_ready |=> !wr_ready);

    // R9
    stop_in_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |-> (wr_ready && wr_valid));

    // R9
    stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |=> !wr_ready);

    // R7
    postdis_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (post_dis_cfg || post_dis_pin) && wr_ready && wr_valid |-> stop_req);

    // R10
    replay_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rp_start |-> (!rp_valid && !wr_ready));

    // R10
    last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rp_last |-> rp_valid);

    // R6
    replay_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rp_valid |-> (rp_cmd == 4'b0111 || rp_cmd == 4'b1111));

    // R11
    resume_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rp_valid && far_disc && !(far_ready && rp_last) |=> rp_start);
endmodule

bind pwb_disconnect_ctl pwb_disconnect_chk u_chk (.*);

// File: tb/sim_pwb_disconnect_ctl.sv
`timescale 1ns/1ps
module sim_pwb_disconnect_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  cmd = 4'b0;
    logic [31:0] addr = '0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic [3:0]  wr_be = '0;
    logic        wr_last = 1'b0;
    logic [7:0]  cls = '0;
    logic [7:0]  burst_lim = '0;
    logic        post_dis_cfg = 1'b0;
    logic        post_dis_pin = 1'b0;
    logic        far_ready = 1'b1;
    logic        far_disc = 1'b0;
    logic        wr_ready, stop_req, rp_start, rp_valid, rp_last;
    logic [31:0] rp_addr, rp_data;
    logic [3:0]  rp_cmd, rp_be;

    int checks = 0;
    int errors = 0;

    pwb_disconnect_ctl u0 (.*);

    always #5 clk = ~clk;

    // Far-side model and replay monitor
    logic [31:0] got_d [16];
    logic [3:0]  got_b [16];
    logic        got_l [16];
    logic [31:0] st_a  [8];
    logic [3:0]  seen_cmd;
    int n_got = 0, n_st = 0, disc_at = 99, nd_at = 99;
    bit nd_pending = 0;

    always @(negedge clk) begin
        if (rp_valid) begin
            bit fr, fd;
            fr = !(nd_pending && n_got == nd_at);
            fd = !fr || (n_got == disc_at);
            if (!fr) nd_pending = 0;
            far_ready = fr;
            far_disc  = fd;
            if (fr && n_got < 16) begin
                got_d[n_got] = rp_data;
                got_b[n_got] = rp_be;
                got_l[n_got] = rp_last;
                seen_cmd = rp_cmd;
                n_got++;
            end
        end else begin
            far_ready = 1'b1;
            far_disc  = 1'b0;
        end
        if (rp_start && n_st < 8) begin
            st_a[n_st] = rp_addr;
            n_st++;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_data(input logic [31:0] a, input int i);
        return 32'hD000_0000 + (a[15:0] << 8) + 32'(i);
    endfunction

    function automatic logic [3:0] mk_be(input int i);
        return 4'hF ^ 4'(i);
    endfunction

    // Runs one burst; returns accepted phase count and the phase carrying stop
    task automatic run_write(input logic [31:0] a, input logic [3:0] c, input int nreq,
                             output int nacc, output int stop_at);
        n_got = 0; n_st = 0; seen_cmd = 4'h0;
        @(posedge clk); #1;
        start = 1'b1; cmd = c; addr = a;
        @(posedge clk); #1;
        start = 1'b0;
        nacc = 0; stop_at = -1;
        for (int i = 0; i < nreq; i++) begin
            bit rdy;
            wr_valid = 1'b1;
            wr_data  = mk_data(a, i);
            wr_be    = mk_be(i);
            wr_last  = (i == nreq - 1);
            @(negedge clk);
            rdy = wr_ready;
            if (rdy) begin
                nacc++;
                if (stop_req) stop_at = i;
            end
            @(posedge clk); #1;
            if (!rdy || stop_at >= 0) break;
        end
        wr_valid = 1'b0;
        wr_last  = 1'b0;
        repeat (25) @(posedge clk);
        #1;
    endtask

    // Checks accepted count, stop placement and a clean single replay
    task automatic burst_case(input logic [31:0] a, input logic [3:0] c, input int nreq,
                              input int exp_acc, input bit exp_stop, input string req);
        int nacc, sat;
        run_write(a, c, nreq, nacc, sat);
        check(nacc == exp_acc, req, nacc, exp_acc);
        check(sat == (exp_stop ? exp_acc - 1 : -1), {req, " stop phase"}, sat, exp_stop ? exp_acc - 1 : -1);
        check(n_got == exp_acc, {req, " replay count"}, n_got, exp_acc);
        if (exp_acc > 0) begin
            bit dok = 1;
            check(n_st == 1 && st_a[0] == a, {req, " R10 replay address"}, st_a[0], a);
            for (int i = 0; i < n_got; i++)
                if (got_d[i] != mk_data(a, i) || got_b[i] != mk_be(i) || got_l[i] != (i == exp_acc - 1)) dok = 0;
            check(dok, {req, " R10 replay data/be/last"}, dok, 1);
        end
    endtask

    task automatic t_reset;
        check(!wr_ready && !stop_req && !rp_start && !rp_valid && !rp_last, "R12 reset outputs",
              {wr_ready, stop_req, rp_start, rp_valid, rp_last}, 0);
    endtask

    task automatic t_plain;
        burst_case(32'h1000_0100, 4'b0111, 3, 3, 0, "R10 plain write");
        check(seen_cmd == 4'b0111, "R6 plain cmd", seen_cmd, 4'b0111);
    endtask

    task automatic t_full;
        burst_case(32'h1000_0200, 4'b0111, 6, 4, 1, "R8 buffer full");
    endtask

    task automatic t_kb;
        burst_case(32'h2000_03FC, 4'b0111, 4, 1, 1, "R2 start at 3FC");
        burst_case(32'h2000_03F8, 4'b0111, 4, 2, 1, "R2 start at 3F8");
    endtask

    task automatic t_line;
        cls = 8'd8;
        burst_case(32'h0000_001C, 4'b1111, 4, 1, 1, "R3 line 8");
        cls = 8'd3;
        burst_case(32'h0000_0010, 4'b1111, 4, 2, 1, "R3 line 3");
        cls = 8'd8;
        burst_case(32'h0000_001C, 4'b0111, 3, 3, 0, "R4 plain write ignores line");
        cls = 8'd20;
        burst_case(32'h0000_001C, 4'b1111, 3, 3, 0, "R4 line size out of range");
        cls = 8'd0;
    endtask

    task automatic t_lim;
        burst_lim = 8'd2;
        burst_case(32'h0000_0100, 4'b0111, 4, 2, 1, "R5 limit 2");
        burst_lim = 8'd3;
        burst_case(32'h0000_0100, 4'b0111, 4, 3, 1, "R5 limit 3");
        burst_lim = 8'd0;
    endtask

    task automatic t_demote;
        cls = 8'd8; burst_lim = 8'd2;
        burst_case(32'h0000_0040, 4'b1111, 4, 2, 1, "R6 demoted burst");
        check(seen_cmd == 4'b0111, "R6 demoted cmd", seen_cmd, 4'b0111);
        burst_lim = 8'd0;
        burst_case(32'h0000_0040, 4'b1111, 4, 4, 1, "R6 kept invalidate");
        check(seen_cmd == 4'b1111, "R6 kept cmd", seen_cmd, 4'b1111);
        cls = 8'd0;
    endtask

    task automatic t_postdis;
        post_dis_cfg = 1'b1;
        burst_case(32'h0000_0300, 4'b0111, 3, 1, 1, "R7 cfg disable");
        post_dis_cfg = 1'b0; post_dis_pin = 1'b1;
        burst_case(32'h0000_0300, 4'b0111, 3, 1, 1, "R7 pin disable");
        post_dis_pin = 1'b0;
    endtask

    task automatic t_resume;
        int nacc, sat;
        bit dok;
        disc_at = 2;
        run_write(32'h3000_03F0, 4'b0111, 4, nacc, sat);
        check(nacc == 4, "R11 accepted", nacc, 4);
        check(n_st == 2, "R11 replay starts", n_st, 2);
        check(st_a[1] == 32'h3000_03FC, "R11 resume address", st_a[1], 32'h3000_03FC);
        dok = (n_got == 4);
        for (int i = 0; i < 4; i++) if (got_d[i] != mk_data(32'h3000_03F0, i)) dok = 0;
        check(dok, "R11 resumed data", n_got, 4);
        disc_at = 99;
        nd_at = 1; nd_pending = 1;
        run_write(32'h4000_0010, 4'b0111, 3, nacc, sat);
        check(n_st == 2 && st_a[1] == 32'h4000_0014, "R11 retry same dword", st_a[1], 32'h4000_0014);
        dok = (n_got == 3);
        for (int i = 0; i < 3; i++) if (got_d[i] != mk_data(32'h4000_0010, i)) dok = 0;
        check(dok, "R11 retry data", n_got, 3);
        nd_at = 99; nd_pending = 0;
    endtask

    task automatic t_nonpost;
        burst_case(32'h0000_0500, 4'b0110, 2, 0, 0, "R1 read not claimed");
        check(n_st == 0, "R1 no replay", n_st, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset;
        rst_n = 1'b1;
        t_plain;
        t_full;
        t_kb;
        t_line;
        t_lim;
        t_demote;
        t_postdis;
        t_resume;
        t_nonpost;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule